// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block is the bus-side state machine of a core that reaches memory over a shared 16-bit address/data path with a 32-bit address space. The core raises a request with a direction, a start address and a word count. The block then runs one address state and one or more data states on a processor clock that is half the input clock. The upper sixteen address bits sit on dedicated pins for the whole transfer. The low address bits go onto the shared lines only in the address state, and an external device must latch them there. A three-bit word index on its own pins steps through the burst.

The master owns every strobe. It marks the address state with an active-high latch pulse and an active-low status strobe. It holds a write/read indication through the cycle. It opens the data window with an active-low enable and points external transceivers with a direction line. An active-low ready input stretches any data state until the target responds. Read words are captured and reported with a per-word pulse and a final done pulse. While the block is idle, an external hold request can take the bus, and the block then floats everything it drives.

Top module: `mux_burst_master`

## Requirements
- R1: Bus states advance only on every second rising edge of `clk`; `procClk` shows the phase, and each address state lasts exactly two `clk` periods.
- R2: In the address state `ale`=1, `asN`=0, `adOe`=1, `adOut` equals address bits 15:0, `busWordAddr` equals address bits 3:1, and `busAddrHi` equals address bits 31:16.
- R3: `busAddrHi` holds the request's bits 31:16 through every data state of the burst.
- R4: `busWordAddr` starts at address bits 3:1 and increases by one after each word completed with ready.
- R5: `wrNotRd` is 1 for a write and 0 for a read, from the address state through the last data state.
- R6: `denN` is low only in data states and never together with `asN` low. In read data states `adOe` is 0. In write data states `adOe` is 1 and `adOut` equals `wrData`.
- R7: `dtR` is 1 for writes and 0 for reads in the address and data states. It never changes while `denN` is low or in the cycle after `denN` was low. A change of direction inserts one idle bus state during which `dtR` switches.
- R8: A data state in which `rdyN` is sampled high repeats, with no `wordAck`, until `rdyN` is sampled low.
- R9: `reqWords` is the word count minus one. The burst ends at index 7 of its aligned 16-byte block, so it carries min(reqWords+1, 8 - address bits 3:1) words. `done` pulses for one clock after the last word, `busy` clears with it, and read words appear on `rdData` together with `wordAck`.
- R10: During reset `asN`, `denN` and `dtR` are 1, and `ale`, `adOe`, `done`, `busy` and `wordAck` are 0.
- R11: With `holdReq` high while the bus is idle, the block enters hold. There `holdAck`=1, `busOe`=0 and `ale`=0, and no cycle starts until `holdReq` falls. Outside hold, `busOe` is 1.
- R12: `reqStart` while not busy is accepted at the next rising edge of `clk`, and `busy` is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the bus state rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Request strobe from the core |
| reqWrite | input | 1 | 1 = write, 0 = read (interrupt acknowledge counts as read) |
| reqAddr | input | 32 | Start byte address |
| reqWords | input | 3 | Word count minus one |
| wrData | input | 16 | Write word for the current data state |
| busy | output | 1 | Request held and not yet finished |
| wordAck | output | 1 | One-clock pulse per completed word |
| rdData | output | 16 | Last captured read word |
| done | output | 1 | One-clock pulse after the final word |
| holdReq | input | 1 | External request to take the bus |
| holdAck | output | 1 | Bus surrendered |
| procClk | output | 1 | Divided processor clock phase |
| busOe | output | 1 | Enable for every three-stateable bus output |
| busAddrHi | output | 16 | Address bits 31:16 |
| busWordAddr | output | 3 | Word index within the 16-byte block |
| adOut | output | 16 | Shared address/data lines, driven value |
| adOe | output | 1 | Drive enable of the shared lines |
| adIn | input | 16 | Shared address/data lines, received value |
| ale | output | 1 | Address latch pulse, active high |
| asN | output | 1 | Address status strobe, active low |
| wrNotRd | output | 1 | Transfer direction, 1 = write |
| denN | output | 1 | Data window enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = transmit |
| rdyN | input | 1 | Target ready, active low |

## Verification
The bench sweeps both directions, all eight start indices and short, middle and full counts. The directions alternate from one burst to the next, so every burst crosses a direction change. A design that failed to clip at the block boundary would run past index 7, keep `denN` low and miss the expected `done`. An index that did not step, or that stepped on a wait state, shows up as a wrong `busWordAddr` in a later data state. Wait states of zero to two per word check that a missed ready sample neither completes the word nor pulses `wordAck`. The hold test places a request inside the hold window. A design that ignored hold would start an address state with the bus floated, and one that did not float would leave `busOe` high.

// File: rtl/mux_burst_master_pkg.sv
package mux_burst_master_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_ADDR,
    ST_DATA,
    ST_HOLD
  } busState_e;

  typedef struct packed {
    logic driveAddr;
    logic setDir;
    logic stepWord;
    logic captureRd;
    logic finish;
  } dpCtl_t;
endpackage

// File: rtl/mux_burst_master_dp.sv
module mux_burst_master_dp
  import mux_burst_master_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int WADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqStart,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [WADDR_W-1:0]   reqWords,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    adIn,
  input  dpCtl_t               ctl,
  output logic                 busy,
  output logic                 writeDir,
  output logic                 dirMatch,
  output logic                 lastWord,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic [WADDR_W-1:0]   busWordAddr,
  output logic [DATA_W-1:0]    adOut,
  output logic [DATA_W-1:0]    rdData,
  output logic                 dtR
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0]  addrR;
  logic [WADDR_W-1:0] endIdx;
  logic [WADDR_W-1:0] wordIdx;
  logic [WADDR_W:0]   endSum;
  logic [WADDR_W-1:0] endClip;

  // last index of the burst, clipped to the end of the aligned block
  assign endSum  = {1'b0, reqAddr[WADDR_W:1]} + {1'b0, reqWords};
  assign endClip = endSum[WADDR_W] ? {WADDR_W{1'b1}} : endSum[WADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      addrR    <= '0;
      writeDir <= 1'b0;
      endIdx   <= '0;
      wordIdx  <= '0;
      dtR      <= 1'b1;
      rdData   <= '0;
    end else begin
      if (reqStart && !busy) begin
        busy     <= 1'b1;
        addrR    <= reqAddr;
        writeDir <= reqWrite;
        endIdx   <= endClip;
        wordIdx  <= reqAddr[WADDR_W:1];
      end else if (ctl.finish) begin
        busy <= 1'b0;
      end
      if (ctl.setDir)    dtR     <= writeDir;
      if (ctl.stepWord)  wordIdx <= wordIdx + WADDR_W'(1);
      if (ctl.captureRd) rdData  <= adIn;
    end
  end

  assign dirMatch    = (dtR == writeDir);
  assign lastWord    = (wordIdx == endIdx);
  assign busAddrHi   = addrR[ADDR_W-1:DATA_W];
  assign busWordAddr = wordIdx;
  assign adOut       = ctl.driveAddr ? addrR[DATA_W-1:0] : wrData;

  initial begin
    if (HI_W < 1) $error("address must be wider than data");
  end
endmodule

// File: rtl/mux_burst_master_ctrl.sv
module mux_burst_master_ctrl
  import mux_burst_master_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   holdReq,
  input  logic   rdyN,
  input  logic   busy,
  input  logic   writeDir,
  input  logic   dirMatch,
  input  logic   lastWord,
  output dpCtl_t ctl,
  output logic   procClk,
  output logic   ale,
  output logic   asN,
  output logic   denN,
  output logic   adOe,
  output logic   busOe,
  output logic   holdAck,
  output logic   wordAck,
  output logic   done
);
  busState_e state, nextState;
  logic      phase;
  logic      wordDone;

  assign procClk  = phase;
  assign wordDone = phase && (state == ST_DATA) && !rdyN;

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.driveAddr = (state == ST_ADDR);
    if (phase) begin
      case (state)
        ST_IDLE: begin
          if (holdReq)    nextState = ST_HOLD;
          else if (busy)  nextState = dirMatch ? ST_ADDR : ST_TURN;
        end
        ST_TURN: begin
          ctl.setDir = 1'b1;
          nextState  = ST_ADDR;
        end
        ST_ADDR: nextState = ST_DATA;
        ST_DATA: begin
          if (!rdyN) begin
            ctl.captureRd = !writeDir;
            ctl.stepWord  = !lastWord;
            ctl.finish    = lastWord;
            nextState     = lastWord ? ST_IDLE : ST_DATA;
          end
        end
        ST_HOLD: if (!holdReq) nextState = ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      state   <= ST_IDLE;
      wordAck <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase   <= ~phase;
      state   <= nextState;
      wordAck <= wordDone;
      done    <= wordDone && lastWord;
    end
  end

  assign ale     = (state == ST_ADDR);
  assign asN     = (state != ST_ADDR);
  assign denN    = (state != ST_DATA);
  assign adOe    = (state == ST_ADDR) || ((state == ST_DATA) && writeDir);
  assign holdAck = (state == ST_HOLD);
  assign busOe   = (state != ST_HOLD);
endmodule

// File: rtl/mux_burst_master.sv
module mux_burst_master
  import mux_burst_master_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int WADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqStart,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [WADDR_W-1:0]       reqWords,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     busy,
  output logic                     wordAck,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done,
  input  logic                     holdReq,
  output logic                     holdAck,
  output logic                     procClk,
  output logic                     busOe,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic [WADDR_W-1:0]       busWordAddr,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     asN,
  output logic                     wrNotRd,
  output logic                     denN,
  output logic                     dtR,
  input  logic                     rdyN
);
  dpCtl_t ctl;
  logic   dirMatch;
  logic   lastWord;

  mux_burst_master_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .rdyN(rdyN), .busy(busy),
    .writeDir(wrNotRd), .dirMatch(dirMatch), .lastWord(lastWord), .ctl(ctl),
    .procClk(procClk), .ale(ale), .asN(asN), .denN(denN), .adOe(adOe),
    .busOe(busOe), .holdAck(holdAck), .wordAck(wordAck), .done(done)
  );

  mux_burst_master_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWords(reqWords), .wrData(wrData), .adIn(adIn),
    .ctl(ctl), .busy(busy), .writeDir(wrNotRd), .dirMatch(dirMatch),
    .lastWord(lastWord), .busAddrHi(busAddrHi), .busWordAddr(busWordAddr),
    .adOut(adOut), .rdData(rdData), .dtR(dtR)
  );
endmodule

// File: rtl/mux_burst_master_chk.sv
module mux_burst_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     asN,
  input logic                     ale,
  input logic                     denN,
  input logic                     dtR,
  input logic                     adOe,
  input logic                     wrNotRd,
  input logic                     done,
  input logic                     holdAck,
  input logic                     busOe,
  input logic [ADDR_W-DATA_W-1:0] busAddrHi
);
  AST_AS_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(asN) |=> !asN); // R1
  AST_ALE_WITH_AS: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !asN); // R2
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!denN && !$past(denN)) |-> $stable(busAddrHi)); // R3
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!denN && !$past(denN)) |-> $stable(wrNotRd)); // R5
  AST_AS_DEN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!asN && !denN)); // R6
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!denN && !dtR) |-> !adOe); // R6
  AST_DTR_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dtR) |-> (denN && $past(denN))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!busOe && !ale)); // R11
endmodule

bind mux_burst_master mux_burst_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .asN(asN), .ale(ale), .denN(denN), .dtR(dtR),
  .adOe(adOe), .wrNotRd(wrNotRd), .done(done), .holdAck(holdAck),
  .busOe(busOe), .busAddrHi(busAddrHi)
);

// File: tb/mux_burst_master_tb.sv
module mux_burst_master_tb;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0, reqWrite = 1'b0, holdReq = 1'b0, rdyN = 1'b1;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqWords = '0;
  logic [15:0] wrData = '0, adIn = '0;
  logic        busy, wordAck, done, holdAck, procClk, busOe, adOe;
  logic        ale, asN, wrNotRd, denN, dtR;
  logic [15:0] rdData, busAddrHi, adOut;
  logic [2:0]  busWordAddr;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  mux_burst_master u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWords(reqWords), .wrData(wrData), .busy(busy),
    .wordAck(wordAck), .rdData(rdData), .done(done), .holdReq(holdReq),
    .holdAck(holdAck), .procClk(procClk), .busOe(busOe), .busAddrHi(busAddrHi),
    .busWordAddr(busWordAddr), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .ale(ale), .asN(asN), .wrNotRd(wrNotRd), .denN(denN), .dtR(dtR), .rdyN(rdyN)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic issueReq(input logic wr, input logic [31:0] a, input logic [2:0] w);
    @(negedge clk);
    reqStart = 1'b1; reqWrite = wr; reqAddr = a; reqWords = w;
    @(negedge clk);
    reqStart = 1'b0;
    chk(busy == 1'b1, "R12 busy after accepted request", busy, 1);
  endtask

  task automatic dataChecks(input logic wr, input logic [31:0] a, input int idx, input logic [15:0] pat);
    chk(denN == 0 && asN == 1 && ale == 0, "R6 data state strobes", {denN, asN, ale}, 3'b010);
    chk(busWordAddr == 3'(idx), "R4 word index", busWordAddr, 3'(idx));
    chk(busAddrHi == a[31:16], "R3 upper address held", busAddrHi, a[31:16]);
    chk(adOe == wr, "R6 data drive enable", adOe, wr);
    if (wr) chk(adOut == pat, "R6 write data on lines", adOut, pat);
    chk(dtR == wr, "R7 direction in data state", dtR, wr);
    chk(wrNotRd == wr, "R5 write/read held", wrNotRd, wr);
  endtask

  task automatic busCycle(input logic wr, input logic [31:0] a, input logic [2:0] w, input int waits);
    int start = int'(a[3:1]);
    int n = (int'(w) + 1 < 8 - start) ? int'(w) + 1 : 8 - start;
    int g = 0;
    while (asN !== 1'b0 && g < 200) begin @(negedge clk); g++; end
    chk(asN == 0 && ale == 1, "R2 address state strobes", {asN, ale}, 2'b01);
    chk(adOe == 1 && adOut == a[15:0], "R2 low address on lines", {adOe, adOut}, {1'b1, a[15:0]});
    chk(busWordAddr == a[3:1], "R2 word index at address", busWordAddr, a[3:1]);
    chk(busAddrHi == a[31:16], "R2 upper address", busAddrHi, a[31:16]);
    chk(busOe == 1, "R11 bus driven outside hold", busOe, 1);
    chk(denN == 1, "R6 no data enable in address state", denN, 1);
    chk(wrNotRd == wr, "R5 direction at address", wrNotRd, wr);
    chk(dtR == wr, "R7 transceiver direction at address", dtR, wr);
    @(negedge clk);
    chk(asN == 0 && procClk == 1, "R1 address state second clock", {asN, procClk}, 2'b01);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [15:0] pat = a[31:16] + 16'(k) * 16'h0101;
      wrData = pat;
      for (int wi = 0; wi < (waits + k) % 3; wi++) begin
        rdyN = 1'b1;
        @(negedge clk);
        dataChecks(wr, a, start + k, pat);
        @(negedge clk);
        chk(wordAck == 0 && denN == 0, "R8 wait state holds word", {wordAck, denN}, 2'b00);
      end
      rdyN = 1'b0; adIn = ~pat;
      @(negedge clk);
      dataChecks(wr, a, start + k, pat);
      @(negedge clk);
      rdyN = 1'b1;
      chk(wordAck == 1, "R8 word completes on ready", wordAck, 1);
      chk(done == (k == n - 1), "R9 done only after last word", done, (k == n - 1));
      if (!wr) chk(rdData == ~pat, "R9 read word captured", rdData, ~pat);
    end
    chk(denN == 1 && busy == 0, "R9 burst length clipped to block", {denN, busy}, 2'b10);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(asN == 1 && denN == 1 && dtR == 1, "R10 reset high strobes", {asN, denN, dtR}, 3'b111);
    chk(ale == 0 && adOe == 0 && done == 0 && busy == 0 && wordAck == 0,
        "R10 reset low outputs", {ale, adOe, done, busy, wordAck}, 0);
    rstN = 1'b1;

    for (int s = 0; s < 8; s++) begin
      for (int wsel = 0; wsel < 3; wsel++) begin
        for (int d = 0; d < 2; d++) begin
          logic [2:0]  w  = (wsel == 0) ? 3'd0 : (wsel == 1) ? 3'd3 : 3'd7;
          logic [31:0] a  = {16'h8000 + 16'(s * 8 + wsel * 2 + d), 12'h3A0 + 12'(wsel), 3'(s), 1'b0};
          logic        wr = (d == 0);
          issueReq(wr, a, w);
          busCycle(wr, a, w, s % 3);
        end
      end
    end

    @(negedge clk);
    holdReq = 1'b1;
    repeat (4) @(negedge clk);
    chk(holdAck == 1 && busOe == 0 && ale == 0, "R11 hold floats bus", {holdAck, busOe, ale}, 3'b100);
    issueReq(1'b0, 32'h1234_5676, 3'd2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(holdAck == 1 && ale == 0 && busOe == 0, "R11 request deferred in hold",
          {holdAck, ale, busOe}, 3'b100);
    end
    holdReq = 1'b0;
    busCycle(1'b0, 32'h1234_5676, 3'd2, 1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule